// File: doc/BRIEF.md
# Video Capture Clock Control Register Bank

This block is the byte-wide control register bank of a video-capture front end. A simple synchronous register bus presents an address, write data, a write strobe and a read strobe; the bank returns read data one cycle after a read strobe. The registers configure the pixel clock path. They hold a fixed silicon revision code, a 12-bit line-length divide ratio, the oscillator band, the charge-pump current, the clock-source choice and a 5-bit sampling phase. Each value is also driven as a decoded output to the clock logic.

The divide ratio is wider than one byte, so it is spread over two addresses and double-buffered. A write to the upper-byte address only fills a staging register. The full 12-bit ratio changes in one step when the low-nibble address is written. On that cycle the staged upper byte and the newly written nibble are committed together, and a one-cycle commit pulse is issued. Software can read the staged byte back before it commits. A committed ratio below 2 raises an error flag. Selecting the external clock source marks the ratio as unused. The sampling phase stays in force in both clock modes.

Top module: `capCtlRegs`

## Requirements
- R1: Address 0x00 reads the fixed revision code given by parameter CHIP_REV. Writes to 0x00 change no output and no read-back value.
- R2: After reset, lineDiv is 1693, vcoBand is 2'b01, pumpSel is 3'b001, extClkSel is 0 and samplePhase is 16. Address 0x01 then reads 0x69 and address 0x02 reads 0xD0.
- R3: A write to 0x01 loads only the staging byte. lineDiv and divCommit do not change, and a later read of 0x01 returns the staged byte.
- R4: A write to 0x02 sets lineDiv to {staged byte, write data bits [7:4]} at that clock edge. divCommit is 1 for exactly the following cycle and is 0 in every cycle that does not follow such a write.
- R5: lineDivErr is 1 exactly while the active lineDiv is below 2. Values 0 and 1 flag the error; 2 through 4095 do not.
- R6: A write to 0x03 sets vcoBand from bits [7:6], pumpSel from bits [5:3] and extClkSel from bit [2]. The register reads back in the same positions.
- R7: lineDivUse is the inverse of extClkSel. samplePhase is not changed by the clock-source choice.
- R8: A write to 0x04 sets samplePhase from bits [7:3]. The register reads back in the same positions.
- R9: Bits [3:0] of 0x02 and bits [1:0] of 0x03 read as 0. Bits [2:0] of 0x04 also read as 0. Addresses above 0x04 read 0x00, and writes to them have no effect.
- R10: busRdData shows the addressed value in the cycle after a read strobe and is 0x00 otherwise. A read issued in the same cycle as a write returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register address |
| busWrData | input | 8 | Write data |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 8 | Read data, registered |
| lineDiv | output | 12 | Active line-length divide ratio |
| lineDivUse | output | 1 | Divide ratio in use (internal clock source) |
| lineDivErr | output | 1 | Active divide ratio below the legal minimum |
| divCommit | output | 1 | One-cycle pulse after the ratio is committed |
| vcoBand | output | 2 | Oscillator band select |
| pumpSel | output | 3 | Charge-pump current select |
| extClkSel | output | 1 | External clock source select |
| samplePhase | output | 5 | Sampling phase step |

## Verification
The hardest case to reach from the ports is a ratio whose value depends on a staged byte written many cycles earlier. Other writes and reads come between the staging and the commit. The bench therefore stages an upper byte, then issues unrelated writes, unmapped accesses and read-backs of the staged byte before committing. It steers the ratio through 0, 1, 2 and 4095 so that the error flag crosses its boundary in both directions. A long pseudo-random run of mixed accesses follows, and a behavioural model checks every output on every cycle.

// File: rtl/capCtlPkg.sv
package capCtlPkg;
  localparam int ADDR_REV   = 0;
  localparam int ADDR_DIVHI = 1;
  localparam int ADDR_DIVLO = 2;
  localparam int ADDR_CLK   = 3;
  localparam int ADDR_PHASE = 4;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_REV, SEL_DIVHI, SEL_DIVLO, SEL_CLK, SEL_PHASE
  } rdSel_t;

  typedef struct packed {
    logic   ldStage;
    logic   ldCommit;
    logic   ldClk;
    logic   ldPhase;
    logic   rdEn;
    rdSel_t rdSel;
  } regStb_t;
endpackage

// File: rtl/capCtlDecode.sv
module capCtlDecode
  import capCtlPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output regStb_t           stb
);
  logic hitRev, hitDivHi, hitDivLo, hitClk, hitPhase;

  always_comb begin
    hitRev   = (busAddr == ADDR_W'(ADDR_REV));
    hitDivHi = (busAddr == ADDR_W'(ADDR_DIVHI));
    hitDivLo = (busAddr == ADDR_W'(ADDR_DIVLO));
    hitClk   = (busAddr == ADDR_W'(ADDR_CLK));
    hitPhase = (busAddr == ADDR_W'(ADDR_PHASE));

    stb.ldStage  = busWrEn & hitDivHi;
    stb.ldCommit = busWrEn & hitDivLo;
    stb.ldClk    = busWrEn & hitClk;
    stb.ldPhase  = busWrEn & hitPhase;
    stb.rdEn     = busRdEn;
    if      (hitRev)   stb.rdSel = SEL_REV;
    else if (hitDivHi) stb.rdSel = SEL_DIVHI;
    else if (hitDivLo) stb.rdSel = SEL_DIVLO;
    else if (hitClk)   stb.rdSel = SEL_CLK;
    else if (hitPhase) stb.rdSel = SEL_PHASE;
    else               stb.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/capCtlData.sv
module capCtlData
  import capCtlPkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          DIV_W     = 12,
  parameter int          PHASE_W   = 5,
  parameter int          DIV_RESET = 1693,
  parameter int          DIV_MIN   = 2,
  parameter int          PHASE_RESET = 16,
  parameter logic [7:0]  CHIP_REV  = 8'h01
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStb_t            stb,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [DIV_W-1:0]   lineDiv,
  output logic               lineDivUse,
  output logic               lineDivErr,
  output logic               divCommit,
  output logic [1:0]         vcoBand,
  output logic [2:0]         pumpSel,
  output logic               extClkSel,
  output logic [PHASE_W-1:0] samplePhase
);
  localparam int LO_W  = DIV_W - DATA_W;
  localparam int CLK_W = 6;
  localparam logic [DIV_W-1:0]   DIV_RST   = DIV_W'(DIV_RESET);
  localparam logic [DIV_W-1:0]   DIV_LIMIT = DIV_W'(DIV_MIN);
  localparam logic [PHASE_W-1:0] PH_RST    = PHASE_W'(PHASE_RESET);

  logic [DATA_W-1:0] divStage;
  logic [DIV_W-1:0]  divActive;
  logic              errQ;
  logic [DATA_W-1:0] rdNext;
  logic [DIV_W-1:0]  divNext;

  assign divNext = {divStage, wrData[DATA_W-1 -: LO_W]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divStage    <= DIV_RST[DIV_W-1 -: DATA_W];
      divActive   <= DIV_RST;
      errQ        <= (DIV_RST < DIV_LIMIT);
      divCommit   <= 1'b0;
      vcoBand     <= 2'b01;
      pumpSel     <= 3'b001;
      extClkSel   <= 1'b0;
      samplePhase <= PH_RST;
      rdData      <= '0;
    end else begin
      divCommit <= stb.ldCommit;
      rdData    <= rdNext;
      if (stb.ldStage) divStage <= wrData;
      if (stb.ldCommit) begin
        divActive <= divNext;
        errQ      <= (divNext < DIV_LIMIT);
      end
      if (stb.ldClk) begin
        vcoBand   <= wrData[DATA_W-1 -: 2];
        pumpSel   <= wrData[DATA_W-3 -: 3];
        extClkSel <= wrData[DATA_W-6];
      end
      if (stb.ldPhase) samplePhase <= wrData[DATA_W-1 -: PHASE_W];
    end
  end

  always_comb begin
    rdNext = '0;
    if (stb.rdEn) begin
      unique case (stb.rdSel)
        SEL_REV:   rdNext = DATA_W'(CHIP_REV);
        SEL_DIVHI: rdNext = divStage;
        SEL_DIVLO: rdNext = {divActive[LO_W-1:0], {(DATA_W-LO_W){1'b0}}};
        SEL_CLK:   rdNext = {vcoBand, pumpSel, extClkSel, {(DATA_W-CLK_W){1'b0}}};
        SEL_PHASE: rdNext = {samplePhase, {(DATA_W-PHASE_W){1'b0}}};
        default:   rdNext = '0;
      endcase
    end
  end

  assign lineDiv    = divActive;
  assign lineDivErr = errQ;
  assign lineDivUse = ~extClkSel;
endmodule

// File: rtl/capCtlRegs.sv
module capCtlRegs
  import capCtlPkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 8,
  parameter int         DIV_W    = 12,
  parameter int         PHASE_W  = 5,
  parameter logic [7:0] CHIP_REV = 8'h01
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic               busWrEn,
  input  logic               busRdEn,
  output logic [DATA_W-1:0]  busRdData,
  output logic [DIV_W-1:0]   lineDiv,
  output logic               lineDivUse,
  output logic               lineDivErr,
  output logic               divCommit,
  output logic [1:0]         vcoBand,
  output logic [2:0]         pumpSel,
  output logic               extClkSel,
  output logic [PHASE_W-1:0] samplePhase
);
  regStb_t stb;

  capCtlDecode #(.ADDR_W(ADDR_W)) decode_i (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .stb(stb)
  );

  capCtlData #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .PHASE_W(PHASE_W), .CHIP_REV(CHIP_REV)
  ) data_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData), .rdData(busRdData),
    .lineDiv(lineDiv), .lineDivUse(lineDivUse), .lineDivErr(lineDivErr),
    .divCommit(divCommit), .vcoBand(vcoBand), .pumpSel(pumpSel),
    .extClkSel(extClkSel), .samplePhase(samplePhase)
  );
endmodule

// File: rtl/capCtlRegsChk.sv
module capCtlRegsChk #(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 8,
  parameter int         DIV_W    = 12,
  parameter int         PHASE_W  = 5,
  parameter logic [7:0] CHIP_REV = 8'h01
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWrEn,
  input logic               busRdEn,
  input logic [DATA_W-1:0]  busRdData,
  input logic [DIV_W-1:0]   lineDiv,
  input logic               lineDivUse,
  input logic               lineDivErr,
  input logic               divCommit,
  input logic               extClkSel,
  input logic [PHASE_W-1:0] samplePhase
);
  a_r1_rev_read: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(0)) |=> (busRdData == DATA_W'(CHIP_REV)));

  a_r3_stage_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(1)) |=> ($stable(lineDiv) && !divCommit));

  a_r4_commit_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(2)) |=> divCommit);

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == ADDR_W'(2)) |=> !divCommit);

  a_r4_ratio_holds: assert property (@(posedge clk) disable iff (!rstN)
    !divCommit |-> ($stable(lineDiv) && $stable(lineDivErr)));

  a_r7_use_off: assert property (@(posedge clk) disable iff (!rstN)
    extClkSel |-> !lineDivUse);

  a_r7_phase_kept: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == ADDR_W'(4)) |=> $stable(samplePhase));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr > ADDR_W'(4)) |=> (busRdData == '0));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> (busRdData == '0));
endmodule

bind capCtlRegs capCtlRegsChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .PHASE_W(PHASE_W), .CHIP_REV(CHIP_REV)
) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busRdData(busRdData), .lineDiv(lineDiv), .lineDivUse(lineDivUse),
  .lineDivErr(lineDivErr), .divCommit(divCommit), .extClkSel(extClkSel),
  .samplePhase(samplePhase)
);

// File: tb/capCtlRegs_tb.sv
module capCtlRegs_tb_top;
  localparam logic [7:0] REV = 8'hA5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0, busWrData = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busRdData;
  logic [11:0] lineDiv;
  logic lineDivUse, lineDivErr, divCommit, extClkSel;
  logic [1:0] vcoBand;
  logic [2:0] pumpSel;
  logic [4:0] samplePhase;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural reference state
  int mStage, mDiv, mVco, mPump, mExt, mPhase, mCommit, mRd;

  always #2 clk = ~clk;

  capCtlRegs #(.CHIP_REV(REV)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData),
    .lineDiv(lineDiv), .lineDivUse(lineDivUse), .lineDivErr(lineDivErr),
    .divCommit(divCommit), .vcoBand(vcoBand), .pumpSel(pumpSel),
    .extClkSel(extClkSel), .samplePhase(samplePhase)
  );

  task automatic expect_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int modelRead(int a);
    case (a)
      0: return REV;
      1: return mStage;
      2: return (mDiv % 16) * 16;
      3: return mVco * 64 + mPump * 8 + mExt * 4;
      4: return mPhase * 8;
      default: return 0;
    endcase
  endfunction

  task automatic modelReset();
    mStage = 8'h69; mDiv = 1693; mVco = 1; mPump = 1; mExt = 0;
    mPhase = 16; mCommit = 0; mRd = 0;
  endtask

  task automatic compareAll();
    expect_eq("R4 lineDiv", lineDiv, mDiv);
    expect_eq("R4 divCommit", divCommit, mCommit);
    expect_eq("R5 lineDivErr", lineDivErr, (mDiv < 2) ? 1 : 0);
    expect_eq("R7 lineDivUse", lineDivUse, 1 - mExt);
    expect_eq("R6 vcoBand", vcoBand, mVco);
    expect_eq("R6 pumpSel", pumpSel, mPump);
    expect_eq("R6 extClkSel", extClkSel, mExt);
    expect_eq("R8 samplePhase", samplePhase, mPhase);
    expect_eq("R10 busRdData", busRdData, mRd);
  endtask

  // one bus cycle: drive after negedge, model at posedge, compare at next negedge
  task automatic busCycle(int a, int d, bit we, bit re);
    busAddr = 8'(a); busWrData = 8'(d); busWrEn = we; busRdEn = re;
    @(posedge clk);
    mRd = re ? modelRead(a) : 0;
    mCommit = (we && a == 2) ? 1 : 0;
    if (we) begin
      case (a)
        1: mStage = d;
        2: mDiv = mStage * 16 + d / 16;
        3: begin mVco = d / 64; mPump = (d / 8) % 8; mExt = (d / 4) % 2; end
        4: mPhase = d / 8;
        default: ;
      endcase
    end
    @(negedge clk);
    busWrEn = 0; busRdEn = 0;
    compareAll();
  endtask

  task automatic wr(int a, int d); busCycle(a, d, 1, 0); endtask
  task automatic rd(int a);        busCycle(a, 0, 0, 1); endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R2 reset state
    expect_eq("R2 lineDiv reset", lineDiv, 1693);
    expect_eq("R2 vco reset", vcoBand, 1);
    expect_eq("R2 pump reset", pumpSel, 1);
    expect_eq("R2 ext reset", extClkSel, 0);
    expect_eq("R2 phase reset", samplePhase, 16);
    rd(1); expect_eq("R2 divhi read", busRdData, 8'h69);
    rd(2); expect_eq("R2 divlo read", busRdData, 8'hD0);
    // R1 revision read-only
    rd(0); expect_eq("R1 rev", busRdData, REV);
    wr(0, 8'h3C); rd(0); expect_eq("R1 rev after write", busRdData, REV);
    // R3 staging
    wr(1, 8'h12); expect_eq("R3 ratio held", lineDiv, 1693);
    expect_eq("R3 no commit", divCommit, 0);
    wr(4, 8'h40); wr(9, 8'hFF);
    rd(1); expect_eq("R3 stage readback", busRdData, 8'h12);
    expect_eq("R3 ratio still held", lineDiv, 1693);
    // R4 commit
    wr(2, 8'h3F); expect_eq("R4 committed", lineDiv, 12'h123);
    expect_eq("R4 pulse", divCommit, 1);
    rd(2); expect_eq("R4 pulse ends", divCommit, 0);
    expect_eq("R9 divlo low bits", busRdData, 8'h30);
    // R5 boundaries
    wr(1, 0); wr(2, 8'h10); expect_eq("R5 ratio1 err", lineDivErr, 1);
    wr(2, 8'h00); expect_eq("R5 ratio0 err", lineDivErr, 1);
    wr(2, 8'h20); expect_eq("R5 ratio2 ok", lineDivErr, 0);
    wr(1, 8'hFF); wr(2, 8'hF0); expect_eq("R5 ratio4095", lineDiv, 4095);
    expect_eq("R5 ratio4095 ok", lineDivErr, 0);
    // R6 / R7 clock register
    wr(3, 8'hFF); expect_eq("R7 use off", lineDivUse, 0);
    expect_eq("R7 phase kept", samplePhase, 8);
    rd(3); expect_eq("R9 clk low bits", busRdData, 8'hFC);
    wr(3, 8'h88); expect_eq("R6 vco", vcoBand, 2);
    expect_eq("R6 pump", pumpSel, 1);
    expect_eq("R7 use on", lineDivUse, 1);
    // R8 phase
    wr(4, 8'hFF); expect_eq("R8 phase", samplePhase, 31);
    rd(4); expect_eq("R9 phase low bits", busRdData, 8'hF8);
    // R9 unmapped
    wr(5, 8'hFF); rd(7); expect_eq("R9 unmapped read", busRdData, 0);
    rd(8'hFF); expect_eq("R9 top read", busRdData, 0);
    // R10 read with write same cycle returns old value
    busCycle(1, 8'h5A, 1, 1); expect_eq("R10 read-before-write", busRdData, 8'hFF);
    rd(1); expect_eq("R10 new value", busRdData, 8'h5A);
    // mixed pseudo-random traffic
    begin
      int lfsr = 32'h1ACE;
      for (int i = 0; i < 600; i++) begin
        lfsr = (lfsr * 1103515245 + 12345) & 32'h7FFFFFFF;
        busCycle((lfsr >> 8) % 7, (lfsr >> 12) % 256, (lfsr >> 3) % 2, (lfsr >> 5) % 2);
      end
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule